// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer

This block is a memory-mapped timer with a parameterised number of independent 32-bit down-counters (three by default). A single start byte, shared by all channels, runs or halts each one. Every channel owns a reload value, a live counter and a small control word that picks the count-clock divider, enables the underflow interrupt and holds the underflow flag. When a running counter sits at zero and its divided clock ticks, it reloads, raises its flag and, when enabled, asserts its own interrupt line until software clears the flag.

Software reaches the registers through a synchronous single-cycle port that accepts byte, halfword and word accesses with data carried on the addressed byte lanes. Loading a counter and its reload value with all ones and letting it run gives a free-running time base: the elapsed tick count is the bitwise inverse of the counter.

Top module: `tmr_unit`

## Requirements
- R1: After reset the start byte reads 0, every reload value and counter reads 0xFFFFFFFF, every control word reads 0 and all interrupt lines are low.
- R2: The start byte is at offset 4 (bit n belongs to channel n, bits above the channel count read 0); channel n starts at offset 8 + 12·n with its reload value at +0, counter at +4 and control word at +8; any other offset reads 0. Read data appears one cycle after the request, lane-aligned, with unaddressed lanes zero.
- R3: Size code 0 is a byte, 1 a halfword, 2 a word; a write changes only the addressed bytes, taking each from its own lane of the write data.
- R4: Control bits [2:0] select the count clock: 0 → /4, 1 → /16, 2 → /64, 3 → /256, 4 to 7 → /1024. The divider is held at zero while the channel is stopped, so the first count comes exactly one divider period after the start bit is set.
- R5: While its start bit is set a channel decrements once per divided tick; while clear its counter holds.
- R6: A tick that finds the counter at zero loads the reload value in its place and sets the flag (control bit 8).
- R7: A channel's interrupt line equals its flag AND its interrupt enable (control bit 5), and changes in the same cycle as either.
- R8: Writing 0 to control bit 8 clears the flag; writing 1 leaves it as it is; an underflow in the same cycle as a clearing write leaves the flag set.
- R9: A write to the counter takes effect at once and replaces any decrement or reload of that cycle.
- R10: The control word keeps only bits [2:0], 5 and 8; all its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data on its byte lanes |
| bus_rdata | output | 32 | Registered read data, lane-aligned |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
Read data is due in the first cycle after the request edge, so the driver queues each expected word tagged with that cycle and the monitor compares it on the following falling edge. Counter, flag and interrupt results are due on the edge that ends a whole number of divider periods after the start-byte write; the bench counts edges exactly between the start and the stop write, then inspects the frozen state through reads, and checks the interrupt lines just after the edge that updates the flag. The coincident-clear and counter-override cases place the write on precisely the edge where a tick lands.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  function automatic logic [LANES-1:0] lane_sel(input logic [1:0] off, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_sel = LANES'(4'b0001 << off);
      SZ_HALF: lane_sel = off[1] ? LANES'(4'b1100) : LANES'(4'b0011);
      default: lane_sel = '1;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] lane_bits(input logic [LANES-1:0] be);
    for (int b = 0; b < LANES; b++) lane_bits[b*8 +: 8] = {8{be[b]}};
  endfunction

  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] cur,
                                                  input logic [BUS_W-1:0] nxt,
                                                  input logic [LANES-1:0] be);
    logic [BUS_W-1:0] m;
    m = lane_bits(be);
    lane_merge = (cur & ~m) | (nxt & m);
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 2,
  parameter int STEP_LOG2 = 2,
  parameter int NUM_TAPS  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PW = BASE_LOG2 + STEP_LOG2 * (NUM_TAPS - 1);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] last;
  int            tap;

  always_comb begin
    tap  = (int'(sel) < NUM_TAPS) ? int'(sel) : NUM_TAPS - 1;
    last = PW'((1 << (BASE_LOG2 + STEP_LOG2 * tap)) - 1);
  end

  assign tick = run && (pcnt >= last);

  always_ff @(posedge clk) begin
    if (rst || !run) pcnt <= '0;
    else if (tick)   pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [LANES-1:0] const_be,
  input  logic [LANES-1:0] cnt_be,
  input  logic [LANES-1:0] ctl_be,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] const_q,
  output logic [BUS_W-1:0] cnt_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             ie_q,
  output logic             flag_q,
  output logic             irq_q
);
  localparam int IE_BIT   = 5;
  localparam int FLAG_BIT = 8;

  logic undf;
  logic flag_d;
  logic ie_d;

  assign undf   = tick && (cnt_q == '0) && !(|cnt_be);
  assign ie_d   = ctl_be[0] ? wdata[IE_BIT] : ie_q;
  assign flag_d = undf ? 1'b1 :
                  (ctl_be[1] && !wdata[FLAG_BIT]) ? 1'b0 : flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      const_q <= '1;
      cnt_q   <= '1;
      sel_q   <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      const_q <= lane_merge(const_q, wdata, const_be);
      if (|cnt_be)   cnt_q <= lane_merge(cnt_q, wdata, cnt_be);
      else if (undf) cnt_q <= const_q;
      else if (tick) cnt_q <= cnt_q - 1'b1;
      if (ctl_be[0]) sel_q <= wdata[SEL_W-1:0];
      ie_q   <= ie_d;
      flag_q <= flag_d;
      irq_q  <= flag_d && ie_d;
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit import tmr_pkg::*; #(
  parameter int NUM_CH    = 3,
  parameter int ADDR_W    = 6,
  parameter int SEL_W     = 3,
  parameter int START_OFS = 4,
  parameter int CH_BASE   = 8,
  parameter int CH_STRIDE = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int WI_W    = ADDR_W - 2;
  localparam int START_W = START_OFS / 4;

  logic [WI_W-1:0]         widx;
  logic [LANES-1:0]        be;
  logic [LANES-1:0]        wr_be;
  logic [NUM_CH-1:0]       start_q;
  logic [NUM_CH-1:0]       ch_tick, ch_ie, ch_flag, ch_cnt_we, ch_flag_clr;
  logic [NUM_CH*BUS_W-1:0] ch_const, ch_cnt;
  logic [NUM_CH*SEL_W-1:0] ch_sel;
  logic [BUS_W-1:0]        rword;

  assign widx  = bus_addr[ADDR_W-1:2];
  assign be    = lane_sel(bus_addr[1:0], bus_size);
  assign wr_be = (bus_en && bus_we) ? be : '0;

  always_ff @(posedge clk) begin
    if (rst) start_q <= '0;
    else if (widx == WI_W'(START_W) && wr_be[0]) start_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int W0 = (CH_BASE + CH_STRIDE * i) / 4;
    logic [LANES-1:0] k_be, c_be, t_be;

    assign k_be = (widx == WI_W'(W0))     ? wr_be : '0;
    assign c_be = (widx == WI_W'(W0 + 1)) ? wr_be : '0;
    assign t_be = (widx == WI_W'(W0 + 2)) ? wr_be : '0;
    assign ch_cnt_we[i]   = |c_be;
    assign ch_flag_clr[i] = t_be[1] && !bus_wdata[8];

    tmr_prescale #(.SEL_W(SEL_W)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .run  (start_q[i]),
      .sel  (ch_sel[i*SEL_W +: SEL_W]),
      .tick (ch_tick[i])
    );

    tmr_channel #(.SEL_W(SEL_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .tick     (ch_tick[i]),
      .const_be (k_be),
      .cnt_be   (c_be),
      .ctl_be   (t_be),
      .wdata    (bus_wdata),
      .const_q  (ch_const[i*BUS_W +: BUS_W]),
      .cnt_q    (ch_cnt[i*BUS_W +: BUS_W]),
      .sel_q    (ch_sel[i*SEL_W +: SEL_W]),
      .ie_q     (ch_ie[i]),
      .flag_q   (ch_flag[i]),
      .irq_q    (irq[i])
    );
  end

  always_comb begin
    rword = '0;
    if (widx == WI_W'(START_W)) rword[NUM_CH-1:0] = start_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (widx == WI_W'((CH_BASE + CH_STRIDE * i) / 4))
        rword = ch_const[i*BUS_W +: BUS_W];
      if (widx == WI_W'((CH_BASE + CH_STRIDE * i) / 4 + 1))
        rword = ch_cnt[i*BUS_W +: BUS_W];
      if (widx == WI_W'((CH_BASE + CH_STRIDE * i) / 4 + 2)) begin
        rword[SEL_W-1:0] = ch_sel[i*SEL_W +: SEL_W];
        rword[5]         = ch_ie[i];
        rword[8]         = ch_flag[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rword & lane_bits(be);
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int NUM_CH = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_CH-1:0]    tick,
  input logic [NUM_CH-1:0]    cnt_we,
  input logic [NUM_CH-1:0]    flag_clr,
  input logic [NUM_CH-1:0]    flag,
  input logic [NUM_CH-1:0]    ie,
  input logic [NUM_CH-1:0]    irq,
  input logic [NUM_CH*32-1:0] cnt,
  input logic [NUM_CH*32-1:0] rld
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
      tick[i] |=> !tick[i]);
    a_r5_decrement: assert property (@(posedge clk) disable iff (rst)
      (tick[i] && !cnt_we[i] && cnt[i*32 +: 32] != 32'd0)
        |=> cnt[i*32 +: 32] == $past(cnt[i*32 +: 32]) - 32'd1);
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (!tick[i] && !cnt_we[i]) |=> $stable(cnt[i*32 +: 32]));
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
      (tick[i] && !cnt_we[i] && cnt[i*32 +: 32] == 32'd0)
        |=> (cnt[i*32 +: 32] == $past(rld[i*32 +: 32])) && flag[i]);
    a_r7_irq_tracks: assert property (@(posedge clk) disable iff (rst)
      irq[i] == (flag[i] && ie[i]));
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && !flag_clr[i]) |=> flag[i]);
  end
endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (ch_tick),
  .cnt_we   (ch_cnt_we),
  .flag_clr (ch_flag_clr),
  .flag     (ch_flag),
  .ie       (ch_ie),
  .irq      (irq),
  .cnt      (ch_cnt),
  .rld      (ch_const)
);

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
  localparam int NUM_CH = 3;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_en = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [1:0]        bus_size = 2'd0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NUM_CH-1:0] irq;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  typedef struct {
    logic [31:0] exp;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];

  tmr_unit #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare read data in the cycle it is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (bus_rdata !== e.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", e.tag, bus_rdata, e.exp);
      end
    end
  end

  task automatic wr(input int addr, input int sz, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr);
    bus_size = 2'(sz); bus_wdata = d;
    @(posedge clk);
    #1 bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int addr, input int sz, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr); bus_size = 2'(sz);
    sb.push_back('{e, cyc + 1, tag});
    @(posedge clk);
    #1 bus_en = 1'b0;
  endtask

  task automatic chk_irq(input logic [NUM_CH-1:0] e, input string tag);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc == 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state, R2 map and unmapped reads
    chk_irq(3'b000, "R1 irq after reset");
    rd(4, 2, 32'h0, "R1 start byte");
    rd(8, 2, 32'hFFFF_FFFF, "R1 reload ch0");
    rd(24, 2, 32'hFFFF_FFFF, "R1 counter ch1");
    rd(40, 2, 32'h0, "R1 control ch2");
    rd(0, 2, 32'h0, "R2 unmapped offset 0");
    rd(44, 2, 32'h0, "R2 unmapped offset 44");

    // R3 partial writes on ch2 reload
    wr(32, 2, 32'h1122_3344);
    wr(33, 0, 32'h0000_AA00);
    wr(34, 1, 32'hBEEF_0000);
    rd(32, 2, 32'hBEEF_AA44, "R3 merged word");
    rd(35, 0, 32'hBE00_0000, "R2 byte read lane 3");
    rd(32, 1, 32'h0000_AA44, "R2 half read low");

    // R4/R5 counting on ch0, /4
    wr(8, 2, 32'd5);
    wr(12, 2, 32'd2);
    wr(16, 1, 32'h0020);
    wr(4, 0, 32'h01);
    repeat (9) @(posedge clk);
    wr(4, 0, 32'h00);
    rd(12, 2, 32'd0, "R5 two decrements in ten cycles");
    rd(16, 1, 32'h0020, "R6 no flag before underflow");
    repeat (5) @(posedge clk);
    rd(12, 2, 32'd0, "R5 stopped counter holds");

    // R6/R7 underflow: first tick exactly four cycles after restart
    wr(4, 0, 32'h01);
    repeat (3) @(posedge clk);
    wr(4, 0, 32'h00);
    chk_irq(3'b001, "R7 irq on underflow");
    rd(12, 2, 32'd5, "R6 reload on underflow");
    rd(16, 1, 32'h0120, "R6 flag set");

    // R8 flag write semantics
    wr(16, 1, 32'h0120);
    chk_irq(3'b001, "R8 write one keeps flag");
    rd(16, 1, 32'h0120, "R8 flag kept");
    wr(16, 1, 32'h0020);
    chk_irq(3'b000, "R8 write zero clears");
    rd(16, 1, 32'h0020, "R8 flag cleared");

    // R10 unused control bits
    wr(28, 2, 32'hFFFF_FFFF);
    rd(28, 2, 32'h0000_0027, "R10 control keeps only defined bits");
    chk_irq(3'b000, "R7 enable without flag");

    // R4 divide by 16 on ch1
    wr(28, 2, 32'h1);
    wr(24, 2, 32'd3);
    wr(4, 0, 32'h02);
    repeat (32) @(posedge clk);
    wr(4, 0, 32'h00);
    rd(24, 2, 32'd1, "R4 divide by 16");

    // R4 select 7 acts as /1024 on ch2
    wr(40, 1, 32'h7);
    wr(36, 2, 32'd3);
    wr(4, 0, 32'h04);
    repeat (1029) @(posedge clk);
    wr(4, 0, 32'h00);
    rd(36, 2, 32'd2, "R4 select 7 divides by 1024");

    // R9 counter write on a tick edge
    wr(12, 2, 32'd100);
    wr(4, 0, 32'h01);
    repeat (3) @(posedge clk);
    wr(12, 2, 32'd50);
    repeat (1) @(posedge clk);
    wr(4, 0, 32'h00);
    rd(12, 2, 32'd50, "R9 write overrides decrement");

    // R8 clear coinciding with underflow
    wr(8, 2, 32'd0);
    wr(12, 2, 32'd0);
    wr(4, 0, 32'h01);
    repeat (7) @(posedge clk);
    wr(16, 1, 32'h0020);
    wr(4, 0, 32'h00);
    rd(16, 1, 32'h0120, "R8 underflow beats clear");
    chk_irq(3'b001, "R8 irq stays with flag");
    wr(16, 1, 32'h0020);
    rd(16, 1, 32'h0020, "R8 later clear works");
    chk_irq(3'b000, "R7 irq drops with flag");

    // R2 start byte width
    wr(4, 0, 32'hFF);
    rd(4, 2, 32'h0000_0007, "R2 start bits above channel count");
    wr(4, 0, 32'h00);

    repeat (3) @(posedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    done = 1;
    finish_run();
  end
endmodule